// File: doc/BRIEF.md
# Fetch-Line Instruction Boundary Predecoder

This block sits behind the instruction fetch stage. Each cycle it can take one aligned 32-byte fetch line, seen as sixteen 16-bit halfword slots. It marks every slot where a variable-length instruction begins and the length of that instruction. Lengths come from the run of ones at the bottom of an instruction's first halfword. Boundaries are chained across the line in one combinational pass, so that each start is found from the start and length of the one before it.

An instruction that runs past slot 15 is held over. Its halfwords are kept, together with the number of halfwords still missing. The next line then begins by finishing that instruction and presents the held halfwords on its join outputs. A flush that comes with a redirected line drops the held state and lets the scan begin at any halfword offset. Results leave through a single registered stage with a valid/ready handshake.

Top module: `fetch_predecoder`

## Requirements
- R1: A first halfword whose low bits hold 0 or 1 consecutive ones, counted from bit 0, is a 16-bit instruction, reported with length code 2'b00.
- R2: A run of 2, 3 or 4 ones gives a 32-bit instruction, reported with length code 2'b01.
- R3: A run of exactly 5 ones gives a 48-bit instruction (code 2'b10), and a run of exactly 6 ones gives a 64-bit instruction (code 2'b11).
- R4: A run of 7 or more ones is reserved. That slot sets its bit in `out_illegal` and is not a start. No later slot of the line is a start, and nothing is held over from the line.
- R5: Starting from the first scanned slot, each start lies one instruction length after the previous start. `out_start` bit i marks slot i. `out_len[2i+1:2i]` carries the length code of slot i, or 2'b00 when slot i is not a start. `out_count` equals the number of bits set in `out_start`.
- R6: When an instruction starts in slot p and its length L halfwords makes p+L greater than 16, the next accepted line that is not a flush has no start below slot p+L-16. That line also reports `out_join_valid`=1, the carried length code in `out_join_len`, the held halfword count 16-p in `out_join_have`, and the held halfwords in `out_join_data`, with the first one in bits 15:0 and unused bits zero. In every other case all four join outputs are zero.
- R7: A line accepted with `in_flush`=1 discards any held-over instruction and begins the scan at slot `in_offset`, so no slot below the offset is a start. Without `in_flush`, `in_offset` has no effect.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid`=1 and `out_ready`=0, every output holds its value and the held-over state does not change.
- R9: After reset, `out_valid` is 0, `in_ready` is 1, and nothing is held over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Fetch line present |
| in_ready | output | 1 | Line accepted this cycle when high with in_valid |
| in_line | input | 256 | Fetch line, slot i in bits 16i+15:16i |
| in_flush | input | 1 | Line is a redirect target; drop held-over state |
| in_offset | input | 4 | First scanned slot of a redirected line |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_start | output | 16 | One bit per slot that starts an instruction |
| out_len | output | 32 | Two-bit length code per slot |
| out_count | output | 5 | Number of starts in the line |
| out_illegal | output | 16 | Slot holding a reserved length, at most one bit |
| out_join_valid | output | 1 | Line begins by finishing a held-over instruction |
| out_join_len | output | 2 | Length code of the held-over instruction |
| out_join_have | output | 2 | Halfwords of it taken from the previous line |
| out_join_data | output | 48 | Those held halfwords, first in bits 15:0 |

## Verification
Two functions can act on the same line. One is a held-over instruction that ends inside the line while the chain carries on after it. The other is the held state being discarded by a flush at an offset, or a new instruction being held over from the tail of that same line. The bench builds lines from chosen length sequences for every format and every flush offset, and follows each flushed line with a plain line that must absorb whatever the first one left behind. Each result is judged against start masks, codes and carried halfwords that the bench worked out while it built the line. A stall placed between a carrying line and its successor shows whether the held state survives back-pressure.

// File: rtl/pd_pkg.sv
// Package: shared constants and length codes of the boundary predecoder.
// Assumes 16-bit halfword slots and instruction lengths of up to four halfwords.
package pd_pkg;
    localparam int HW_W     = 16;  // bits per halfword slot
    localparam int PEEK_W   = 7;   // low bits inspected for the length run
    localparam int CARRY_HW = 3;   // most halfwords an instruction can leave behind

    typedef enum logic [1:0] {
        LEN16 = 2'b00,
        LEN32 = 2'b01,
        LEN48 = 2'b10,
        LEN64 = 2'b11
    } len_code_e;
endpackage

// File: rtl/pd_len_decode.sv
// Module: length classifier for one halfword slot.
// Counts the run of ones starting at bit 0 and maps it to a length code.
// Assumes the slot is a candidate first halfword; the chain decides if it is.
module pd_len_decode
    import pd_pkg::*;
(
    input  logic [PEEK_W-1:0] hw_low,
    output logic [1:0]        code,
    output logic              illegal
);
    // Map the trailing-ones run to a length code or the reserved flag.
    always_comb begin
        code    = LEN16;
        illegal = 1'b0;
        casez (hw_low)
            7'b??????0: code = LEN16;
            7'b?????01: code = LEN16;
            7'b????011: code = LEN32;
            7'b???0111: code = LEN32;
            7'b??01111: code = LEN32;
            7'b?011111: code = LEN48;
            7'b0111111: code = LEN64;
            default:    illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/pd_boundary_chain.sv
// Module: combinational boundary chain over one fetch line.
// Starting at begin_pos, hops from start to start by the per-slot length,
// stops at a reserved slot, and reports an instruction that spills past the end.
// Assumes per-slot codes were computed for every slot in parallel.
module pd_boundary_chain #(
    parameter int SLOTS = 16,
    localparam int POS_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0][1:0] slot_code,
    input  logic [SLOTS-1:0]      slot_ill,
    input  logic [POS_W-1:0]      begin_pos,
    output logic [SLOTS-1:0]      start_mask,
    output logic [SLOTS-1:0][1:0] len_codes,
    output logic [SLOTS-1:0]      ill_mask,
    output logic [CNT_W-1:0]      start_cnt,
    output logic                  tail_valid,
    output logic [POS_W-1:0]      tail_pos,
    output logic [1:0]            tail_code,
    output logic [1:0]            tail_need
);
    int   nxt;
    logic stopped;

    // Walk the slots once, marking each start and the next expected start.
    always_comb begin
        start_mask = '0;
        len_codes  = '0;
        ill_mask   = '0;
        start_cnt  = '0;
        tail_valid = 1'b0;
        tail_pos   = '0;
        tail_code  = '0;
        tail_need  = '0;
        stopped    = 1'b0;
        nxt        = int'(begin_pos);
        for (int i = 0; i < SLOTS; i++) begin
            if (!stopped && i == nxt) begin
                if (slot_ill[i]) begin
                    ill_mask[i] = 1'b1;
                    stopped     = 1'b1;
                end else begin
                    start_mask[i] = 1'b1;
                    len_codes[i]  = slot_code[i];
                    start_cnt     = start_cnt + CNT_W'(1);
                    nxt           = i + int'(slot_code[i]) + 1;
                    if (nxt > SLOTS) begin
                        tail_valid = 1'b1;
                        tail_pos   = POS_W'(i);
                        tail_code  = slot_code[i];
                        tail_need  = 2'(nxt - SLOTS);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pd_carry_store.sv
// Module: holds the halfwords of an instruction that spilled past a line.
// Loads on every accepted line: keeps the spill if there is one, else empties.
// Assumes tail_pos points at a start whose length crosses the line end.
module pd_carry_store
    import pd_pkg::*;
#(
    parameter int SLOTS = 16,
    localparam int POS_W   = $clog2(SLOTS),
    localparam int LINE_W  = SLOTS * HW_W,
    localparam int CARRY_W = CARRY_HW * HW_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [LINE_W-1:0]  line,
    input  logic               tail_valid,
    input  logic [POS_W-1:0]   tail_pos,
    input  logic [1:0]         tail_code,
    input  logic [1:0]         tail_need,
    output logic [1:0]         carry_need,
    output logic [1:0]         carry_code,
    output logic [1:0]         carry_have,
    output logic [CARRY_W-1:0] carry_data
);
    // Capture or clear the held-over instruction on each accepted line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_need <= '0;
            carry_code <= '0;
            carry_have <= '0;
            carry_data <= '0;
        end else if (load) begin
            if (tail_valid) begin
                carry_need <= tail_need;
                carry_code <= tail_code;
                carry_have <= 2'(SLOTS - int'(tail_pos));
                carry_data <= CARRY_W'(line >> (int'(tail_pos) * HW_W));
            end else begin
                carry_need <= '0;
                carry_code <= '0;
                carry_have <= '0;
                carry_data <= '0;
            end
        end
    end

    // R6
    carry_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_need != 2'd0 |->
            ({1'b0, carry_have} + {1'b0, carry_need}) == ({1'b0, carry_code} + 3'd1));
endmodule

// File: rtl/fetch_predecoder.sv
// Module: top of the fetch-line boundary predecoder.
// Classifies every slot in parallel, chains the boundaries from the carried
// count or the flush offset, and registers the result behind valid/ready.
// Assumes aligned lines of SLOTS halfwords; in_offset is honoured only with in_flush.
module fetch_predecoder
    import pd_pkg::*;
#(
    parameter int SLOTS = 16,
    localparam int POS_W   = $clog2(SLOTS),
    localparam int CNT_W   = $clog2(SLOTS + 1),
    localparam int LINE_W  = SLOTS * HW_W,
    localparam int CARRY_W = CARRY_HW * HW_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [LINE_W-1:0]  in_line,
    input  logic               in_flush,
    input  logic [POS_W-1:0]   in_offset,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [SLOTS-1:0]   out_start,
    output logic [2*SLOTS-1:0] out_len,
    output logic [CNT_W-1:0]   out_count,
    output logic [SLOTS-1:0]   out_illegal,
    output logic               out_join_valid,
    output logic [1:0]         out_join_len,
    output logic [1:0]         out_join_have,
    output logic [CARRY_W-1:0] out_join_data
);
    logic [SLOTS-1:0][1:0] slot_code;
    logic [SLOTS-1:0]      slot_ill;
    logic [SLOTS-1:0]      start_mask;
    logic [SLOTS-1:0][1:0] len_codes;
    logic [SLOTS-1:0]      ill_mask;
    logic [CNT_W-1:0]      start_cnt;
    logic                  tail_valid;
    logic [POS_W-1:0]      tail_pos;
    logic [1:0]            tail_code;
    logic [1:0]            tail_need;
    logic [1:0]            carry_need;
    logic [1:0]            carry_code;
    logic [1:0]            carry_have;
    logic [CARRY_W-1:0]    carry_data;
    logic                  accept;
    logic                  joining;
    logic [POS_W-1:0]      begin_pos;

    // One length classifier per slot, all in parallel.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        pd_len_decode u_dec (
            .hw_low  (in_line[g*HW_W +: PEEK_W]),
            .code    (slot_code[g]),
            .illegal (slot_ill[g])
        );
    end

    // Handshake and scan origin for the incoming line.
    always_comb begin
        in_ready  = !out_valid || out_ready;
        accept    = in_valid && in_ready;
        joining   = !in_flush && (carry_need != 2'd0);
        begin_pos = in_flush ? in_offset : POS_W'(carry_need);
    end

    pd_boundary_chain #(.SLOTS(SLOTS)) u_chain (
        .slot_code  (slot_code),
        .slot_ill   (slot_ill),
        .begin_pos  (begin_pos),
        .start_mask (start_mask),
        .len_codes  (len_codes),
        .ill_mask   (ill_mask),
        .start_cnt  (start_cnt),
        .tail_valid (tail_valid),
        .tail_pos   (tail_pos),
        .tail_code  (tail_code),
        .tail_need  (tail_need)
    );

    pd_carry_store #(.SLOTS(SLOTS)) u_carry (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .line       (in_line),
        .tail_valid (tail_valid),
        .tail_pos   (tail_pos),
        .tail_code  (tail_code),
        .tail_need  (tail_need),
        .carry_need (carry_need),
        .carry_code (carry_code),
        .carry_have (carry_have),
        .carry_data (carry_data)
    );

    // Output stage: load on accept, drop when consumed, hold when stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            out_start      <= '0;
            out_len        <= '0;
            out_count      <= '0;
            out_illegal    <= '0;
            out_join_valid <= 1'b0;
            out_join_len   <= '0;
            out_join_have  <= '0;
            out_join_data  <= '0;
        end else if (accept) begin
            out_valid      <= 1'b1;
            out_start      <= start_mask;
            out_len        <= len_codes;
            out_count      <= start_cnt;
            out_illegal    <= ill_mask;
            out_join_valid <= joining;
            out_join_len   <= joining ? carry_code : 2'd0;
            out_join_have  <= joining ? carry_have : 2'd0;
            out_join_data  <= joining ? carry_data : '0;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R5
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_count == CNT_W'($countones(out_start)));

    // R4
    illegal_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_illegal) && ((out_illegal & out_start) == '0));

    // R6
    join_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_join_valid) |-> !out_start[0]);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_start) && $stable(out_len) && $stable(out_count)));

    // R8
    stall_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(carry_need) && $stable(carry_data)));
endmodule

// File: tb/test_fetch_predecoder.sv
// Bench: builds lines from chosen length sequences and predicts the outputs
// while building them, sweeping every format and every flush offset.
module test_fetch_predecoder;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [255:0] in_line = '0;
    logic         in_flush = 1'b0;
    logic [3:0]   in_offset = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [15:0]  out_start;
    logic [31:0]  out_len;
    logic [4:0]   out_count;
    logic [15:0]  out_illegal;
    logic         out_join_valid;
    logic [1:0]   out_join_len;
    logic [1:0]   out_join_have;
    logic [47:0]  out_join_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // model state and expectations
    int           m_need = 0, m_have = 0, m_code = 0;
    logic [47:0]  m_data = '0;
    logic [255:0] g_line;
    logic [15:0]  e_start, e_ill;
    logic [31:0]  e_len;
    int           e_cnt;
    logic         e_jv;
    logic [1:0]   e_jl, e_jh;
    logic [47:0]  e_jd;

    always #2 clk = ~clk;

    fetch_predecoder i_fetch_predecoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_line(in_line), .in_flush(in_flush), .in_offset(in_offset),
        .out_valid(out_valid), .out_ready(out_ready), .out_start(out_start),
        .out_len(out_len), .out_count(out_count), .out_illegal(out_illegal),
        .out_join_valid(out_join_valid), .out_join_len(out_join_len),
        .out_join_have(out_join_have), .out_join_data(out_join_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Build one line. mode 0 mixed with rare reserved, 1..4 one format, 5 mixed,
    // 6 reserved at the first scanned slot.
    task automatic gen(input int mode, input bit fl, input int off);
        int pos, c, nn, nh, nc;
        logic [15:0] hw;
        logic [47:0] nd;
        bit ill;
        e_jv = !fl && (m_need != 0);
        e_jl = e_jv ? 2'(m_code) : 2'd0;
        e_jh = e_jv ? 2'(m_have) : 2'd0;
        e_jd = e_jv ? m_data : '0;
        e_start = '0; e_ill = '0; e_len = '0; e_cnt = 0;
        nn = 0; nh = 0; nc = 0; nd = '0;
        for (int i = 0; i < 16; i++) g_line[i*16 +: 16] = 16'($urandom);
        pos = fl ? off : m_need;
        while (pos < 16) begin
            ill = 1'b0;
            case (mode)
                1: c = 0;
                2: c = 1;
                3: c = 2;
                4: c = 3;
                5: c = int'($urandom % 4);
                6: begin c = 0; ill = 1'b1; end
                default: begin
                    c = int'($urandom % 20);
                    ill = (c == 0);
                    c = c % 4;
                end
            endcase
            hw = g_line[pos*16 +: 16];
            if (ill) begin
                hw[6:0] = 7'h7F;
                g_line[pos*16 +: 16] = hw;
                e_ill[pos] = 1'b1;
                break;
            end
            case (c)
                0: hw[1:0] = 2'($urandom % 3);
                1: begin hw[1:0] = 2'b11; hw[4:2] = 3'($urandom % 7); end
                2: hw[5:0] = 6'h1F;
                default: hw[6:0] = 7'h3F;
            endcase
            g_line[pos*16 +: 16] = hw;
            e_start[pos] = 1'b1;
            e_len[pos*2 +: 2] = 2'(c);
            e_cnt++;
            if (pos + c + 1 > 16) begin
                nn = pos + c + 1 - 16;
                nh = 16 - pos;
                nc = c;
                nd = 48'(g_line >> (pos * 16));
            end
            pos = pos + c + 1;
        end
        m_need = nn; m_have = nh; m_code = nc; m_data = nd;
    endtask

    task automatic check_out(input int mode);
        string lr;
        case (mode)
            1: lr = "R1";
            2: lr = "R2";
            3, 4: lr = "R3";
            6: lr = "R4";
            default: lr = "R5";
        endcase
        chk(out_valid == 1'b1, "R5", "out_valid", 256'(out_valid), 256'(1));
        chk(out_start == e_start, lr, "start mask", 256'(out_start), 256'(e_start));
        chk(out_len == e_len, lr, "length codes", 256'(out_len), 256'(e_len));
        chk(out_count == 5'(e_cnt), "R5", "count", 256'(out_count), 256'(e_cnt));
        chk(out_illegal == e_ill, "R4", "illegal mask", 256'(out_illegal), 256'(e_ill));
        chk(out_join_valid == e_jv, "R6", "join valid", 256'(out_join_valid), 256'(e_jv));
        chk(out_join_len == e_jl, "R6", "join len", 256'(out_join_len), 256'(e_jl));
        chk(out_join_have == e_jh, "R6", "join have", 256'(out_join_have), 256'(e_jh));
        chk(out_join_data == e_jd, "R6", "join data", 256'(out_join_data), 256'(e_jd));
    endtask

    // Drive one line, let it be accepted, check at the following falling edge.
    task automatic run(input int mode, input bit fl, input int off);
        @(negedge clk);
        gen(mode, fl, off);
        in_line   = g_line;
        in_flush  = fl;
        in_offset = fl ? 4'(off) : 4'($urandom); // R7: offset ignored without flush
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_flush = 1'b0;
        check_out(mode);
    endtask

    initial begin
        logic [15:0] s_start;
        logic [31:0] s_len;
        logic [4:0]  s_cnt;
        void'($urandom(7));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(out_valid == 1'b0, "R9", "out_valid after reset", 256'(out_valid), 256'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R9", "in_ready after reset", 256'(in_ready), 256'(1));
        // R9: first line sees nothing held over
        run(4, 1'b0, 0);
        // R7 and R6: every format at every flush offset, then a plain follower
        for (int md = 1; md <= 6; md++) begin
            for (int off = 0; off < 16; off++) begin
                run(md, 1'b1, off);
                run(5, 1'b0, 0);
                run(md, 1'b0, 0);
            end
        end
        // R1..R5: mixed traffic with occasional reserved slots
        for (int k = 0; k < 400; k++) run(0, ($urandom % 8) == 0, int'($urandom % 16));
        // R8: back-pressure across a carrying line
        @(negedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        gen(4, 1'b1, 1);
        in_line = g_line; in_flush = 1'b1; in_offset = 4'd1; in_valid = 1'b1;
        @(negedge clk);
        in_flush = 1'b0;
        check_out(4);
        s_start = out_start; s_len = out_len; s_cnt = out_count;
        gen(5, 1'b0, 0);
        in_line = g_line; in_offset = 4'($urandom);
        chk(in_ready == 1'b0, "R8", "in_ready while stalled", 256'(in_ready), 256'(0));
        repeat (3) begin
            @(negedge clk);
            chk(out_valid == 1'b1, "R8", "valid held", 256'(out_valid), 256'(1));
            chk(out_start == s_start, "R8", "start held", 256'(out_start), 256'(s_start));
            chk(out_len == s_len, "R8", "len held", 256'(out_len), 256'(s_len));
            chk(out_count == s_cnt, "R8", "count held", 256'(out_count), 256'(s_cnt));
        end
        out_ready = 1'b1;
        #0;
        chk(in_ready == 1'b1, "R8", "in_ready when consumer ready", 256'(in_ready), 256'(1));
        @(negedge clk);
        in_valid = 1'b0;
        check_out(5); // R8: carry survived the stall
        @(negedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", "valid drops once taken", 256'(out_valid), 256'(0));
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule